// File: doc/BRIEF.md
# Frame-Aligned DDR Serial Word Receiver

This block turns eight serial lanes back into parallel 10-bit words. Each lane carries one bit per half-period of a forwarded bit clock, so a word spans five bit-clock periods. A frame signal travels with the lanes. It is high for the first half of each word, and its rising edge marks the slot that carries the least significant bit. The block samples the lane bits, the bit-clock level and the frame level in its own fabric clock. That clock runs at twice the slot rate, so every slot is seen in two consecutive fabric cycles.

A slot is taken as new whenever the sampled bit-clock level changes. The block captures the lane bits one fabric cycle after that change, near the middle of the slot. A frame rising edge restarts the bit count. The ten bits that follow are reassembled least significant bit first. All eight words then appear together with a single-cycle valid strobe. If a frame rising edge arrives at a slot where no word was due to begin, the block raises a one-cycle alignment error, drops the partial word and counts again from that edge.

Top module: `ddr_word_rx`

## Requirements
- R1: While reset is low and in the cycle after it is released, `valid_o` and `align_err_o` are 0 and `words_o` is all zeros.
- R2: After reset, `valid_o` and `align_err_o` stay 0 until the first frame rising edge. Such an edge is a captured slot with frame high whose previously captured slot had frame low. The first captured slot after reset never counts as an edge.
- R3: A slot is captured once for each change of the sampled `bclk_i` level. Holding `bclk_i` steady for more than two cycles adds no bits and produces no extra valid.
- R4: The slot that carries the frame rising edge supplies bit 0 of every word, and the nine slots after it supply bits 1 to 9 in order. Lane k is `lane_i[k]`, and its word is `words_o[k*10 +: 10]`.
- R5: `valid_o` is high for exactly one cycle per completed word. It rises in the third fabric cycle after the first cycle in which the bit-9 slot is present at the inputs, with all eight words updated in that same cycle.
- R6: When a frame rising edge arrives while locked and the next expected bit is not bit 0, `align_err_o` pulses for one cycle. The pulse comes in the third cycle after the first cycle of that slot. The partial word is dropped with no valid, and that slot becomes bit 0.
- R7: A frame rising edge at the expected bit-0 slot, or the first rising edge after reset, raises no alignment error.
- R8: `words_o` changes only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, two cycles per serial slot |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | Sampled level of the forwarded bit clock; toggles every slot |
| frame_i | input | 1 | Sampled frame level; high in slots 0 to 4 of a word |
| lane_i | input | 8 | Serial data bit of each lane |
| words_o | output | 80 | Recovered words, lane k at bits k*10 +: 10 |
| valid_o | output | 1 | One-cycle strobe when all words are updated |
| align_err_o | output | 1 | One-cycle pulse on a misplaced frame rising edge |

## Verification
Both results move through three registers: the input samplers, the mid-slot capture stage and the word/flag outputs. `valid_o` is therefore due three fabric cycles after the bit-9 slot is first driven, and `align_err_o` three cycles after the offending bit-0 slot. The bench drives each slot on a falling edge and records the posedge count at that moment. It queues the expected cycle as that count plus three, together with the expected words. A falling-edge monitor then requires every strobe to appear in exactly its queued cycle with the queued data. Any strobe nobody queued, or any queued strobe that fails to appear, is reported as a failure.

// File: rtl/rxw_pkg.sv
// Shared defaults and types for the DDR serial word receiver.
package rxw_pkg;
    localparam int DEF_LANES  = 8;
    localparam int DEF_WORD_W = 10;

    // Word-alignment state of the frame tracker.
    typedef enum logic {
        SYNC_SEEK  = 1'b0,
        SYNC_TRACK = 1'b1
    } sync_state_t;
endpackage

// File: rtl/ddr_slot_sampler.sv
// Input sampler. It registers the bit-clock level, the frame level and the
// lane bits, detects each bit-clock level change, and captures all of them
// one cycle later, near the middle of a two-cycle slot.
// Assumes: the fabric clock runs at twice the slot rate and the inputs are
// already synchronous to it.
module ddr_slot_sampler #(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             frame_i,
    input  logic [LANES-1:0] lane_i,
    output logic             cap_stb_o,
    output logic             cap_frame_o,
    output logic [LANES-1:0] cap_bits_o
);
    logic             bclk_s;
    logic             bclk_p;
    logic             frame_s;
    logic [LANES-1:0] lane_s;

    // Input registers and previous bit-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_s  <= 1'b0;
            bclk_p  <= 1'b0;
            frame_s <= 1'b0;
            lane_s  <= '0;
        end else begin
            bclk_s  <= bclk_i;
            bclk_p  <= bclk_s;
            frame_s <= frame_i;
            lane_s  <= lane_i;
        end
    end

    // Mid-slot capture, one cycle after a bit-clock level change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_stb_o   <= 1'b0;
            cap_frame_o <= 1'b0;
            cap_bits_o  <= '0;
        end else begin
            cap_stb_o   <= bclk_s ^ bclk_p;
            cap_frame_o <= frame_s;
            cap_bits_o  <= lane_s;
        end
    end
endmodule

// File: rtl/ddr_frame_tracker.sv
// Frame tracker. It finds frame rising edges among captured slots, keeps the
// expected bit index, and issues shift and word-complete controls. It also
// registers the valid strobe and the misalignment pulse.
// Assumes: the frame is high for the first slots of a word and low before
// the next word begins.
module ddr_frame_tracker
    import rxw_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_stb_i,
    input  logic cap_frame_i,
    output logic take_o,
    output logic last_o,
    output logic locked_o,
    output logic valid_o,
    output logic align_err_o
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    sync_state_t      state;
    logic [IDX_W-1:0] idx;
    logic             frame_prev;
    logic             rise;

    // Edge detect and shift controls for the current captured slot.
    always_comb begin
        rise     = cap_stb_i && cap_frame_i && !frame_prev;
        locked_o = (state == SYNC_TRACK);
        take_o   = cap_stb_i && (rise || locked_o);
        last_o   = cap_stb_i && !rise && locked_o && (idx == LAST_IDX);
    end

    // Lock state, bit index and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SYNC_SEEK;
            idx         <= '0;
            frame_prev  <= 1'b1;
            valid_o     <= 1'b0;
            align_err_o <= 1'b0;
        end else begin
            valid_o     <= last_o;
            align_err_o <= rise && locked_o && (idx != '0);
            if (cap_stb_i) begin
                frame_prev <= cap_frame_i;
                if (rise) begin
                    state <= SYNC_TRACK;
                    idx   <= IDX_W'(1);
                end else if (locked_o) begin
                    idx <= (idx == LAST_IDX) ? '0 : IDX_W'(idx + 1'b1);
                end
            end
        end
    end
endmodule

// File: rtl/ddr_lane_shifter.sv
// Per-lane deserialiser. Each captured bit enters at the MSB end, so after
// the full word the register holds it in natural order with bit 0 first in
// time. The finished word goes to a holding register on the last bit.
// Assumes: take and last come from the frame tracker in the capture cycle.
module ddr_lane_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              last_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shifted;

    // Next shift register value with the new bit at the MSB.
    always_comb begin
        if (WORD_W > 1) shifted = {bit_i, shreg[WORD_W-1:1]};
        else            shifted = WORD_W'(bit_i);
    end

    // Shift on each accepted bit; publish on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            word_o <= '0;
        end else begin
            if (take_i) shreg <= shifted;
            if (last_i) word_o <= shifted;
        end
    end
endmodule

// File: rtl/ddr_word_rx.sv
// Top level of the frame-aligned DDR serial word receiver. It ties the
// sampler, the frame tracker and one shifter per lane together.
// Assumes: the fabric clock samples every slot twice.
module ddr_word_rx
    import rxw_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bclk_i,
    input  logic                    frame_i,
    input  logic [LANES-1:0]        lane_i,
    output logic [LANES*WORD_W-1:0] words_o,
    output logic                    valid_o,
    output logic                    align_err_o
);
    logic             cap_stb;
    logic             cap_frame;
    logic [LANES-1:0] cap_bits;
    logic             take;
    logic             last;
    logic             locked;

    ddr_slot_sampler #(.LANES(LANES)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk_i),
        .frame_i     (frame_i),
        .lane_i      (lane_i),
        .cap_stb_o   (cap_stb),
        .cap_frame_o (cap_frame),
        .cap_bits_o  (cap_bits)
    );

    ddr_frame_tracker #(.WORD_W(WORD_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_stb_i   (cap_stb),
        .cap_frame_i (cap_frame),
        .take_o      (take),
        .last_o      (last),
        .locked_o    (locked),
        .valid_o     (valid_o),
        .align_err_o (align_err_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ddr_lane_shifter #(.WORD_W(WORD_W)) u_shift (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_i (take),
            .last_i (last),
            .bit_i  (cap_bits[g]),
            .word_o (words_o[g*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/rxw_checker.sv
// Protocol checker for the receiver, attached to every instance by bind.
module rxw_checker #(
    parameter int OUT_W = 80
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_o,
    input logic             align_err_o,
    input logic [OUT_W-1:0] words_o,
    input logic             locked,
    input logic             cap_stb
);
    // R5
    single_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R2
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || align_err_o) |-> locked);

    // R8
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(words_o) |-> valid_o);

    // R6
    err_drops_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |-> !valid_o);

    // R3
    valid_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(cap_stb));
endmodule

bind ddr_word_rx rxw_checker #(.OUT_W(LANES*WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_o     (valid_o),
    .align_err_o (align_err_o),
    .words_o     (words_o),
    .locked      (locked),
    .cap_stb     (cap_stb)
);

// File: tb/ddr_word_rx_tb.sv
// Directed bench for the DDR serial word receiver. A transmitter model in
// tasks drives slots on falling edges; a falling-edge monitor matches each
// strobe against queued expectations.
module ddr_word_rx_tb;
    localparam int L = 8;
    localparam int W = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bclk = 1'b0;
    logic           frame = 1'b0;
    logic [L-1:0]   lane = '0;
    logic [L*W-1:0] words;
    logic           valid;
    logic           aerr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int             vdue_q[$];
    logic [L*W-1:0] vexp_q[$];
    int             edue_q[$];

    ddr_word_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk),
        .frame_i     (frame),
        .lane_i      (lane),
        .words_o     (words),
        .valid_o     (valid),
        .align_err_o (aerr)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [L*W-1:0] got,
                       input logic [L*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Strobe monitor: timing and data of every valid and error pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                if (vdue_q.size() == 0) chk(1'b0, "R5 unexpected valid", 80'(cyc), 80'(0));
                else begin
                    chk(cyc == vdue_q[0], "R5 valid cycle", 80'(cyc), 80'(vdue_q[0]));
                    chk(words == vexp_q[0], "R4 words", words, vexp_q[0]);
                    void'(vdue_q.pop_front());
                    void'(vexp_q.pop_front());
                end
            end else if (vdue_q.size() > 0 && cyc > vdue_q[0]) begin
                chk(1'b0, "R5 missing valid", 80'(cyc), 80'(vdue_q[0]));
                void'(vdue_q.pop_front());
                void'(vexp_q.pop_front());
            end
            if (aerr) begin
                if (edue_q.size() == 0) chk(1'b0, "R7 unexpected align_err", 80'(cyc), 80'(0));
                else begin
                    chk(cyc == edue_q[0], "R6 align_err cycle", 80'(cyc), 80'(edue_q[0]));
                    void'(edue_q.pop_front());
                end
            end else if (edue_q.size() > 0 && cyc > edue_q[0]) begin
                chk(1'b0, "R6 missing align_err", 80'(cyc), 80'(edue_q[0]));
                void'(edue_q.pop_front());
            end
        end
    end

    // One slot: toggle the bit clock, drive data and frame, hold for n cycles.
    task automatic drive_slot(input logic [L-1:0] d, input logic f, input int hold);
        bclk  = ~bclk;
        lane  = d;
        frame = f;
        repeat (hold) @(negedge clk);
    endtask

    // Whole word: ten slots, frame high for the first five, LSB first.
    task automatic send_word(input logic [L*W-1:0] w, input bit exp_valid,
                             input bit exp_err, input int hold);
        for (int s = 0; s < W; s++) begin
            logic [L-1:0] d;
            for (int k = 0; k < L; k++) d[k] = w[k*W + s];
            if (s == 0 && exp_err) edue_q.push_back(cyc + 3);
            if (s == W-1 && exp_valid) begin
                vdue_q.push_back(cyc + 3);
                vexp_q.push_back(w);
            end
            drive_slot(d, s < 5, hold);
        end
    endtask

    function automatic logic [L*W-1:0] pattern(input int seed);
        logic [L*W-1:0] r;
        for (int k = 0; k < L; k++) r[k*W +: W] = W'(seed * 37 + k * 101 + 5);
        return r;
    endfunction

    task automatic drain_check(input string req);
        repeat (6) @(negedge clk);
        chk(vdue_q.size() == 0 && edue_q.size() == 0, req,
            80'(vdue_q.size()), 80'(0));
    endtask

    // R1: reset values, during reset and just after release.
    task automatic t_reset();
        rst_n = 1'b0;
        bclk = 1'b0; frame = 1'b0; lane = '0;
        repeat (4) @(negedge clk);
        chk(valid == 1'b0 && aerr == 1'b0 && words == '0, "R1 in reset", words, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 1'b0 && aerr == 1'b0 && words == '0, "R1 after release", words, '0);
    endtask

    // R2: idle slots and a half word with frame low give no strobe.
    task automatic t_prelock();
        int seen = 0;
        for (int s = 0; s < 15; s++) begin
            drive_slot(L'(s * 29), 1'b0, 2);
            if (valid || aerr) seen++;
        end
        repeat (4) @(negedge clk);
        if (valid || aerr) seen++;
        chk(seen == 0, "R2 no strobe before first frame edge", 80'(seen), 80'(0));
    endtask

    // R4 R5 R7: lock and receive several distinct patterns back to back.
    task automatic t_stream();
        logic [L*W-1:0] ones;
        logic [L*W-1:0] lsb;
        logic [L*W-1:0] msb;
        ones = '1;
        for (int k = 0; k < L; k++) begin
            lsb[k*W +: W] = W'(1);
            msb[k*W +: W] = W'(1) << (W-1);
        end
        send_word(pattern(1), 1'b1, 1'b0, 2);
        send_word(lsb, 1'b1, 1'b0, 2);
        send_word(msb, 1'b1, 1'b0, 2);
        send_word(ones, 1'b1, 1'b0, 2);
        send_word(pattern(7), 1'b1, 1'b0, 2);
        drain_check("R5 R7 stream strobes all matched");
    endtask

    // R3: slots held for three cycles still yield one bit each.
    task automatic t_stall();
        send_word(pattern(11), 1'b1, 1'b0, 3);
        send_word(pattern(12), 1'b1, 1'b0, 4);
        drain_check("R3 stalled bit clock");
    endtask

    // R6: a frame edge after seven slots drops the partial word.
    task automatic t_misalign();
        logic [L*W-1:0] part;
        part = pattern(20);
        for (int s = 0; s < 7; s++) begin
            logic [L-1:0] d;
            for (int k = 0; k < L; k++) d[k] = part[k*W + s];
            drive_slot(d, s < 5, 2);
        end
        send_word(pattern(21), 1'b1, 1'b1, 2);
        send_word(pattern(22), 1'b1, 1'b0, 2);
        drain_check("R6 resync after misplaced edge");
        @(negedge clk);
        chk(words == pattern(22), "R8 words held after last valid", words, pattern(22));
    endtask

    // R2 R1: reset mid-word, then the next frame edge locks again.
    task automatic t_relock();
        drive_slot(8'hA5, 1'b1, 2);
        drive_slot(8'h5A, 1'b1, 2);
        rst_n = 1'b0;
        vdue_q.delete(); vexp_q.delete(); edue_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(words == '0 && !valid, "R1 cleared by mid-run reset", words, '0);
        for (int s = 0; s < 3; s++) drive_slot(8'hFF, 1'b0, 2);
        send_word(pattern(30), 1'b1, 1'b0, 2);
        drain_check("R2 relock after reset");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_prelock();
        t_stream();
        t_stall();
        t_misalign();
        t_relock();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule